// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a single-data-rate SDRAM interface and owns the command pins from reset until the memory is ready for normal use. After reset it keeps the clock enable and the data masks high and issues no command during a long stabilisation wait. It then closes every bank with one precharge-all command and issues a burst of auto-refresh commands. Last, it loads the mode register with the read latency, burst type and burst length chosen on its configuration inputs.

Every gap between two commands is a parameter counted in clock cycles, and the stabilisation wait is derived from the clock frequency and a time in microseconds. The sequencer drives the minimum legal spacing exactly. It raises a ready flag once the mode-register recovery time has passed, and that flag stays high until the next reset. A surrounding controller takes over the pins when ready is high. Traffic and periodic refresh are outside this block.

Top module: `sdram_boot_seq`

## Requirements
- R1: `sd_cke` and every bit of `sd_dqm` are high in every cycle, from reset onward.
- R2: After reset is released, no command is issued for exactly STABLE_CYC = CLK_MHZ*STABLE_US clock edges. The first command appears on edge STABLE_CYC.
- R3: The first command is precharge-all: `sd_cs_n`=0, `sd_ras_n`=0, `sd_cas_n`=1, `sd_we_n`=0, with `sd_addr[10]`=1 and all other address and bank bits 0.
- R4: The first auto-refresh (`cs_n`=0, `ras_n`=0, `cas_n`=0, `we_n`=1, address and bank 0) appears exactly TRP_CYC cycles after the precharge-all.
- R5: Exactly REF_COUNT auto-refreshes are issued, and never fewer than eight. Consecutive refreshes are exactly TRC_CYC cycles apart.
- R6: A mode-register load (`cs_n`, `ras_n`, `cas_n` and `we_n` all 0) follows the last refresh by exactly TRC_CYC cycles. On it, `sd_ba`=0 and `sd_addr[11:7]`=0. The mode fields are placed as follows: `sd_addr[6:4]` carries `cfg_cas_lat`, `sd_addr[3]` carries `cfg_burst_type`, and `sd_addr[2:0]` carries `cfg_burst_len`.
- R7: `sd_cs_n` is low only in command cycles. In every other cycle `sd_cs_n`, `sd_ras_n`, `sd_cas_n` and `sd_we_n` are all 1, and `sd_addr` and `sd_ba` are 0.
- R8: `init_done` rises exactly TRSC_CYC cycles after the mode-register load and stays high until reset. No command is issued while it is high.
- R9: A reset asserted part-way through the sequence returns the pins to the idle pattern, and the whole sequence starts again with the full stabilisation wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_burst_len | input | 3 | Burst length code for the mode word |
| cfg_burst_type | input | 1 | Burst ordering bit for the mode word (0 sequential, 1 interleaved) |
| cfg_cas_lat | input | 3 | Read latency code for the mode word |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address bus |
| sd_dqm | output | DQM_W | Data masks |
| init_done | output | 1 | Sequence complete, memory ready |

## Verification
The bound checker checks the following on every cycle:
- The idle pin pattern, and that a selected cycle is never a no-operation.
- The precharge-all address bit.
- The spacing from each command to the one before it.
- The refresh total seen before the mode load.
- The zeroed upper bits of the mode word and the field placement.
- That ready is sticky and silent.

Two properties need the bench's per-cycle reference schedule. The length of the stabilisation wait is not visible to the checker, which only measures gaps between commands. The restart after a reset in the middle of the refresh burst also needs the bench. The bench additionally checks that the mode word follows a change of configuration between runs.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_PREA = 2'd1,
        CMD_REF  = 2'd2,
        CMD_MRS  = 2'd3
    } boot_cmd_e;

    typedef enum logic [2:0] {
        ST_STABLE = 3'd0,
        ST_TRP    = 3'd1,
        ST_TRC    = 3'd2,
        ST_TRSC   = 3'd3,
        ST_DONE   = 3'd4
    } boot_st_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam cmd_pins_t PINS_IDLE = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

endpackage

// File: rtl/boot_delay_ctr.sv
module boot_delay_ctr #(
    parameter int CNT_W   = 16,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/boot_cmd_enc.sv
module boot_cmd_enc
    import sdram_boot_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2
) (
    input  boot_cmd_e         cmd,
    input  logic [2:0]        burst_len,
    input  logic              burst_type,
    input  logic [2:0]        cas_lat,
    output cmd_pins_t         pins,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);
    localparam int AP_BIT = 10;

    always_comb begin
        pins = PINS_IDLE;
        ba   = '0;
        addr = '0;
        case (cmd)
            CMD_PREA: begin
                pins         = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
                addr[AP_BIT] = 1'b1;
            end
            CMD_REF: begin
                pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            end
            CMD_MRS: begin
                pins      = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
                addr[6:4] = cas_lat;
                addr[3]   = burst_type;
                addr[2:0] = burst_len;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
    import sdram_boot_pkg::*;
#(
    parameter int CLK_MHZ   = 125,
    parameter int STABLE_US = 200,
    parameter int TRP_CYC   = 3,
    parameter int TRC_CYC   = 9,
    parameter int TRSC_CYC  = 2,
    parameter int REF_COUNT = 8,
    parameter int ADDR_W    = 12,
    parameter int BA_W      = 2,
    parameter int DQM_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_burst_type,
    input  logic [2:0]        cfg_cas_lat,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BA_W-1:0]   sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic              init_done
);
    localparam int STABLE_CYC = CLK_MHZ * STABLE_US;
    localparam int REF_N      = (REF_COUNT < 8) ? 8 : REF_COUNT;
    localparam int GAP_MAX    = (TRC_CYC > TRP_CYC) ?
                                ((TRC_CYC > TRSC_CYC) ? TRC_CYC : TRSC_CYC) :
                                ((TRP_CYC > TRSC_CYC) ? TRP_CYC : TRSC_CYC);
    localparam int WAIT_MAX   = (STABLE_CYC > GAP_MAX) ? STABLE_CYC : GAP_MAX;
    localparam int CNT_W      = $clog2(WAIT_MAX + 1);
    localparam int REF_W      = $clog2(REF_N + 1);

    typedef struct packed {
        boot_st_e         st;
        logic [REF_W-1:0] refs;
        logic             done;
    } seq_t;

    seq_t              seq_d, seq_q;
    boot_cmd_e         cmd_d;
    logic              load;
    logic [CNT_W-1:0]  load_val;
    logic              expired;
    cmd_pins_t         pins_d, pins_q;
    logic [BA_W-1:0]   ba_d, ba_q;
    logic [ADDR_W-1:0] addr_d, addr_q;

    boot_delay_ctr #(
        .CNT_W   (CNT_W),
        .RST_VAL (STABLE_CYC - 1)
    ) gap_ctr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    // Next step of the start-up order; a command leaves on the edge after expiry.
    always_comb begin
        seq_d    = seq_q;
        cmd_d    = CMD_NOP;
        load     = 1'b0;
        load_val = '0;
        case (seq_q.st)
            ST_STABLE: if (expired) begin
                cmd_d    = CMD_PREA;
                load     = 1'b1;
                load_val = CNT_W'(TRP_CYC - 1);
                seq_d.st = ST_TRP;
            end
            ST_TRP: if (expired) begin
                cmd_d      = CMD_REF;
                load       = 1'b1;
                load_val   = CNT_W'(TRC_CYC - 1);
                seq_d.refs = REF_W'(1);
                seq_d.st   = ST_TRC;
            end
            ST_TRC: if (expired) begin
                load = 1'b1;
                if (seq_q.refs == REF_W'(REF_N)) begin
                    cmd_d    = CMD_MRS;
                    load_val = CNT_W'(TRSC_CYC - 1);
                    seq_d.st = ST_TRSC;
                end else begin
                    cmd_d      = CMD_REF;
                    load_val   = CNT_W'(TRC_CYC - 1);
                    seq_d.refs = seq_q.refs + 1'b1;
                end
            end
            ST_TRSC: if (expired) begin
                seq_d.done = 1'b1;
                seq_d.st   = ST_DONE;
            end
            default: ;
        endcase
    end

    boot_cmd_enc #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W)
    ) enc_i (
        .cmd        (cmd_d),
        .burst_len  (cfg_burst_len),
        .burst_type (cfg_burst_type),
        .cas_lat    (cfg_cas_lat),
        .pins       (pins_d),
        .ba         (ba_d),
        .addr       (addr_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q  <= '{st: ST_STABLE, refs: '0, done: 1'b0};
            pins_q <= PINS_IDLE;
            ba_q   <= '0;
            addr_q <= '0;
        end else begin
            seq_q  <= seq_d;
            pins_q <= pins_d;
            ba_q   <= ba_d;
            addr_q <= addr_d;
        end
    end

    assign sd_cke    = 1'b1;
    assign sd_dqm    = '1;
    assign sd_cs_n   = pins_q.cs_n;
    assign sd_ras_n  = pins_q.ras_n;
    assign sd_cas_n  = pins_q.cas_n;
    assign sd_we_n   = pins_q.we_n;
    assign sd_ba     = ba_q;
    assign sd_addr   = addr_q;
    assign init_done = seq_q.done;

endmodule

// File: rtl/sdram_boot_chk.sv
module sdram_boot_chk #(
    parameter int TRP_CYC  = 3,
    parameter int TRC_CYC  = 9,
    parameter int TRSC_CYC = 2,
    parameter int REF_N    = 8,
    parameter int ADDR_W   = 12,
    parameter int BA_W     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        cfg_burst_len,
    input logic              cfg_burst_type,
    input logic [2:0]        cfg_cas_lat,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [BA_W-1:0]   sd_ba,
    input logic [ADDR_W-1:0] sd_addr,
    input logic              init_done
);
    localparam logic [1:0] K_NONE = 2'd0;
    localparam logic [1:0] K_PREA = 2'd1;
    localparam logic [1:0] K_REF  = 2'd2;
    localparam logic [1:0] K_MRS  = 2'd3;

    logic        is_cmd, is_prea, is_ref, is_mrs;
    logic [1:0]  kind_q;
    logic [15:0] gap_q;
    logic [15:0] refs_q;

    assign is_cmd  = !sd_cs_n;
    assign is_prea = is_cmd && !sd_ras_n &&  sd_cas_n && !sd_we_n;
    assign is_ref  = is_cmd && !sd_ras_n && !sd_cas_n &&  sd_we_n;
    assign is_mrs  = is_cmd && !sd_ras_n && !sd_cas_n && !sd_we_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= K_NONE;
            gap_q  <= '0;
            refs_q <= '0;
        end else begin
            if (is_cmd) begin
                gap_q <= 16'd1;
            end else if (gap_q != 16'hFFFF) begin
                gap_q <= gap_q + 16'd1;
            end
            if (is_prea) kind_q <= K_PREA;
            if (is_ref) begin
                kind_q <= K_REF;
                refs_q <= refs_q + 16'd1;
            end
            if (is_mrs) kind_q <= K_MRS;
        end
    end

    AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cs_n |-> (sd_ras_n && sd_cas_n && sd_we_n && sd_addr == '0 && sd_ba == '0)); // R7

    AST_SELECT_IS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmd |-> !(sd_ras_n && sd_cas_n && sd_we_n)); // R7

    AST_PREA_FIRST_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        is_prea |-> (sd_addr[10] && kind_q == K_NONE)); // R3

    AST_FIRST_REF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref && kind_q == K_PREA) |-> gap_q == 16'(TRP_CYC)); // R4

    AST_REF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref && kind_q == K_REF) |-> gap_q == 16'(TRC_CYC)); // R5

    AST_REF_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> (kind_q == K_PREA || kind_q == K_REF)); // R4

    AST_MRS_AFTER_REFS: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> (kind_q == K_REF && gap_q == 16'(TRC_CYC) && refs_q == 16'(REF_N))); // R5

    AST_MRS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> (sd_ba == '0 && sd_addr[ADDR_W-1:7] == '0 &&
                    sd_addr[6:0] == {$past(cfg_cas_lat), $past(cfg_burst_type), $past(cfg_burst_len)})); // R6

    AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (kind_q == K_MRS && gap_q == 16'(TRSC_CYC))); // R8

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done); // R8

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> sd_cs_n); // R8

endmodule

bind sdram_boot_seq sdram_boot_chk #(
    .TRP_CYC  (TRP_CYC),
    .TRC_CYC  (TRC_CYC),
    .TRSC_CYC (TRSC_CYC),
    .REF_N    (REF_N),
    .ADDR_W   (ADDR_W),
    .BA_W     (BA_W)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_burst_len  (cfg_burst_len),
    .cfg_burst_type (cfg_burst_type),
    .cfg_cas_lat    (cfg_cas_lat),
    .sd_cs_n        (sd_cs_n),
    .sd_ras_n       (sd_ras_n),
    .sd_cas_n       (sd_cas_n),
    .sd_we_n        (sd_we_n),
    .sd_ba          (sd_ba),
    .sd_addr        (sd_addr),
    .init_done      (init_done)
);

// File: tb/sdram_boot_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_boot_seq_tb_top;

    localparam int CLK_MHZ   = 125;
    localparam int STABLE_US = 200;
    localparam int TRP       = 3;
    localparam int TRC       = 9;
    localparam int TRSC      = 2;
    localparam int NREF      = 8;
    localparam int STABLE    = CLK_MHZ * STABLE_US;
    localparam int T_MRS     = STABLE + TRP + NREF * TRC;
    localparam int T_DONE    = T_MRS + TRSC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_bl = 3'd3;
    logic        cfg_bt = 1'b0;
    logic [2:0]  cfg_cl = 3'd3;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;
    logic [1:0]  sd_dqm;

    int checks = 0;
    int errors = 0;
    int ref_seen;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sdram_boot_seq #(
        .CLK_MHZ (CLK_MHZ), .STABLE_US (STABLE_US), .TRP_CYC (TRP),
        .TRC_CYC (TRC), .TRSC_CYC (TRSC), .REF_COUNT (NREF)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .cfg_burst_len (cfg_bl), .cfg_burst_type (cfg_bt), .cfg_cas_lat (cfg_cl),
        .sd_cke (sd_cke), .sd_cs_n (sd_cs_n), .sd_ras_n (sd_ras_n),
        .sd_cas_n (sd_cas_n), .sd_we_n (sd_we_n), .sd_ba (sd_ba),
        .sd_addr (sd_addr), .sd_dqm (sd_dqm), .init_done (init_done)
    );

    task automatic check(input bit ok, input string req, input string what, input int k,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s edge %0d: actual %h expected %h", req, what, k, act, exp);
        end
    endtask

    // Behavioural schedule: command kind expected k edges after reset release.
    function automatic string exp_kind(input int k);
        if (k == STABLE) return "PREA";
        for (int i = 0; i < NREF; i++)
            if (k == STABLE + TRP + i * TRC) return "REF";
        if (k == T_MRS) return "MRS";
        return "NOP";
    endfunction

    task automatic compare(input int k);
        string       kind;
        string       req;
        logic [3:0]  exp_pins;
        logic [11:0] exp_addr;
        kind     = exp_kind(k);
        exp_addr = 12'd0;
        req      = "R7";
        case (kind)
            "PREA": begin exp_pins = 4'b0010; exp_addr = 12'h400; req = "R3"; end
            "REF":  begin exp_pins = 4'b0001; req = (k == STABLE + TRP) ? "R4" : "R5"; end
            "MRS":  begin exp_pins = 4'b0000; exp_addr = {5'd0, cfg_cl, cfg_bt, cfg_bl}; req = "R6"; end
            default: begin exp_pins = 4'b1111; if (k < STABLE) req = "R2"; end
        endcase
        if (kind == "REF") ref_seen++;
        check(sd_cke == 1'b1 && sd_dqm == 2'b11, "R1", "cke/dqm", k, {sd_cke, sd_dqm}, 3'b111);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == exp_pins, req, "pins", k,
              {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, exp_pins);
        check(sd_addr == exp_addr && sd_ba == 2'b00, req, "addr/ba", k, {sd_ba, sd_addr}, exp_addr);
        check(init_done == (k >= T_DONE), "R8", "init_done", k, init_done, (k >= T_DONE));
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        compare(0);
        rst_n = 1'b1;
        ref_seen = 0;
    endtask

    task automatic run_edges(input int n);
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            compare(k);
        end
    endtask

    initial begin
        // Run 1: read latency 3, sequential, burst length 8
        do_reset();
        run_edges(T_DONE + 20);
        check(ref_seen == NREF, "R5", "refresh total", 0, ref_seen, NREF);

        // Run 2: reset after two refreshes, configuration changed; restart expected
        cfg_cl = 3'd2; cfg_bt = 1'b1; cfg_bl = 3'd2;
        do_reset();
        run_edges(STABLE + TRP + TRC + 4);
        do_reset();   // R9: idle pins during reset checked at edge 0
        run_edges(T_DONE + 20);
        check(ref_seen == NREF, "R9", "refresh total after restart", 0, ref_seen, NREF);
        check(init_done == 1'b1, "R9", "ready after restart", 0, init_done, 1'b1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule